// File: doc/BRIEF.md
# Delay-Race Challenge-Response Generator

This block emulates, in whole clock cycles, an identification circuit built from a race between two signal paths. A chain of switch stages, one per challenge bit, carries two lanes. A launch event enters both lanes at the same moment. At each stage the challenge bit either passes the lanes straight through or crosses them. Every stage has its own small delays for each lane and setting. These delays are fixed at elaboration from a seed parameter, which stands in for manufacturing variation between chips. An arbiter at the end of the chain records which lane's signal arrived first.

A controller builds an N-bit response word. It runs N races in sequence, each with a fresh challenge taken from a 16-bit LFSR, and gathers one bit per race. Software pulses `start` with a challenge seed, waits for `resp_valid`, and reads `response`. Two instances with different seed parameters give different words for the same challenge seed. One instance always reproduces its own word.

The controller has three states. `ST_IDLE` waits for start. The transition *launch* (start seen) loads the LFSR and moves to `ST_RACE`. In `ST_RACE` the arbiter's timer runs. The transition *resolve-next* (a race is decided and bits remain) stores the bit, steps the LFSR and stays in `ST_RACE`. The transition *resolve-last* (the final bit is decided) moves to `ST_DONE`. `ST_DONE` pulses `resp_valid`, and the transition *finish* returns to `ST_IDLE`.

Top module: `race_id_gen`

## Requirements
- R1: After reset, `busy` and `resp_valid` are 0 and `response` is all zeros.
- R2: A `start` sampled high in idle raises `busy` at the next clock edge and loads the challenge seed into the LFSR. A seed of 0 is replaced by 1.
- R3: The LFSR is a 16-bit right-shifting Galois register. On each step the old bit 0 shifts out, and if that bit was 1 the register is XORed with 0xB400. Race k (counting from 0) uses the state after k steps, and its challenge is the low CHAL_W bits of that state. Bit i of the challenge drives stage i.
- R4: The delay of stage i, setting s (0 = straight, 1 = crossed), entering lane l (0 = upper, 1 = lower) is 1 + h[1:0]. To get h, start from SEED XOR (idx * 0x9E3779B9) with idx = 4i+2s+l. Then XOR h with h>>16, multiply by 0x045D9F3B (32-bit), and XOR with h>>16 again.
- R5: Both lanes start at time 0. A straight stage adds each lane its own straight delay. A crossed stage moves the upper lane's signal to the lower lane, adding the upper-entry crossed delay, and moves the lower lane's signal to the upper lane, adding the lower-entry crossed delay.
- R6: The race bit is 1 only when the signal leaving on the upper lane arrives strictly earlier. If both arrive in the same cycle, the bit is 0.
- R7: Bit k of `response` holds the result of race k. `resp_valid` is a one-cycle pulse in the last busy cycle. `response` holds its value until the next accepted start.
- R8: `start` is ignored while `busy` is high. The running response and its timing are unchanged.
- R9: The same challenge seed on the same instance always gives the same response.
- R10: Instances whose SEED parameters differ give different responses for some challenge seeds.
- R11: Race k takes (first arrival time + 1) cycles. `resp_valid` is seen exactly the sum of these over all races clock edges after the edge that accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a response when idle |
| chal_seed | input | 16 | Seed for the challenge LFSR |
| busy | output | 1 | Response in progress |
| resp_valid | output | 1 | One-cycle strobe, response complete |
| response | output | RESP_W | Collected response word, bit k from race k |

## Verification
The embedded assertions watch several properties on every cycle. They check that an accepted start raises busy, that `resp_valid` is a single pulse followed by idle, and that the response holds while idle. They also check that a start during a run does not stop it, that the LFSR never holds zero, and that the race timer never passes the longest possible path. Only the bench's scenarios can show the values themselves. These are the steered-path arrival rule, the tie rule, the LFSR challenge sequence, the exact run latency, reproducibility, and the difference between two seeded instances. The bench checks them against an independent model of the delay formula.

// File: rtl/race_id_pkg.sv
package race_id_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RACE = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_t;

    localparam int unsigned LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;
    localparam int unsigned DLY_MAX   = 4;

    // Emulated per-stage delay in cycles: 1..4, derived from the seed.
    function automatic int unsigned stage_delay(
        input logic [31:0] seed,
        input int unsigned stage,
        input int unsigned setting,
        input int unsigned lane
    );
        logic [31:0] h;
        logic [31:0] idx;
        idx = 32'(4 * stage + 2 * setting + lane);
        h = seed ^ (idx * 32'h9E3779B9);
        h = h ^ (h >> 16);
        h = h * 32'h045D9F3B;
        h = h ^ (h >> 16);
        return 32'(h[1:0]) + 1;
    endfunction

endpackage

// File: rtl/challenge_lfsr.sv
module challenge_lfsr
    import race_id_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] stepped;

    always_comb begin
        stepped = state >> 1;
        if (state[0]) begin
            stepped = stepped ^ LFSR_TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LFSR_W'(1);
        end else if (load) begin
            state <= (seed == '0) ? LFSR_W'(1) : seed;
        end else if (step) begin
            state <= stepped;
        end
    end

    // R3: a Galois register loaded with a nonzero value never reaches zero
    a_r3_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

endmodule

// File: rtl/race_chain.sv
module race_chain
    import race_id_pkg::*;
#(
    parameter int unsigned CHAL_W = 16,
    parameter logic [31:0] SEED   = 32'h1F2E3D4C,
    parameter int unsigned TW     = 7
) (
    input  logic [CHAL_W-1:0] challenge,
    output logic [TW-1:0]     t_upper,
    output logic [TW-1:0]     t_lower
);

    logic [TW-1:0] up_t [CHAL_W+1];
    logic [TW-1:0] lo_t [CHAL_W+1];

    assign up_t[0] = '0;
    assign lo_t[0] = '0;

    for (genvar i = 0; i < CHAL_W; i++) begin : g_stage
        localparam int unsigned D_UP_STR = stage_delay(SEED, i, 0, 0);
        localparam int unsigned D_LO_STR = stage_delay(SEED, i, 0, 1);
        localparam int unsigned D_UP_X   = stage_delay(SEED, i, 1, 0);
        localparam int unsigned D_LO_X   = stage_delay(SEED, i, 1, 1);

        always_comb begin
            if (challenge[i]) begin
                up_t[i+1] = lo_t[i] + TW'(D_LO_X);
                lo_t[i+1] = up_t[i] + TW'(D_UP_X);
            end else begin
                up_t[i+1] = up_t[i] + TW'(D_UP_STR);
                lo_t[i+1] = lo_t[i] + TW'(D_LO_STR);
            end
        end
    end

    assign t_upper = up_t[CHAL_W];
    assign t_lower = lo_t[CHAL_W];

endmodule

// File: rtl/race_arbiter.sv
module race_arbiter #(
    parameter int unsigned TW     = 7,
    parameter int unsigned T_MAX  = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] t_upper,
    input  logic [TW-1:0] t_lower,
    output logic          decided,
    output logic          upper_wins
);

    logic [TW-1:0] timer;
    logic          up_here;
    logic          lo_here;

    assign up_here    = (timer >= t_upper);
    assign lo_here    = (timer >= t_lower);
    assign decided    = run && (up_here || lo_here);
    // a tie (both present in the same cycle) resolves to 0
    assign upper_wins = up_here && !lo_here;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (!run || decided) begin
            timer <= '0;
        end else begin
            timer <= timer + 1'b1;
        end
    end

    // R11: every race resolves no later than the longest possible path
    a_r11_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (timer <= TW'(T_MAX)));

endmodule

// File: rtl/race_id_gen.sv
module race_id_gen
    import race_id_pkg::*;
#(
    parameter int unsigned CHAL_W = 16,
    parameter int unsigned RESP_W = 8,
    parameter logic [31:0] SEED   = 32'h1F2E3D4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       chal_seed,
    output logic              busy,
    output logic              resp_valid,
    output logic [RESP_W-1:0] response
);

    localparam int unsigned T_MAX = CHAL_W * DLY_MAX;
    localparam int unsigned TW    = $clog2(T_MAX + 2);
    localparam int unsigned BW    = (RESP_W > 1) ? $clog2(RESP_W) : 1;

    ctrl_state_t       state_q;
    ctrl_state_t       state_d;
    logic [LFSR_W-1:0] lfsr_state;
    logic [TW-1:0]     t_upper;
    logic [TW-1:0]     t_lower;
    logic              decided;
    logic              upper_wins;
    logic              racing;
    logic              launch;
    logic              last_bit;
    logic [BW-1:0]     bit_idx;
    logic [RESP_W-1:0] resp_q;

    assign launch   = (state_q == ST_IDLE) && start;
    assign racing   = (state_q == ST_RACE);
    assign last_bit = (bit_idx == BW'(RESP_W - 1));

    challenge_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .seed  (chal_seed),
        .step  (decided),
        .state (lfsr_state)
    );

    race_chain #(
        .CHAL_W (CHAL_W),
        .SEED   (SEED),
        .TW     (TW)
    ) u_chain (
        .challenge (lfsr_state[CHAL_W-1:0]),
        .t_upper   (t_upper),
        .t_lower   (t_lower)
    );

    race_arbiter #(
        .TW    (TW),
        .T_MAX (T_MAX)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (racing),
        .t_upper    (t_upper),
        .t_lower    (t_lower),
        .decided    (decided),
        .upper_wins (upper_wins)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: launch, resolve-next, resolve-last, finish
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RACE;
            ST_RACE: if (decided && last_bit) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // bit collection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            resp_q  <= '0;
        end else if (launch) begin
            bit_idx <= '0;
            resp_q  <= '0;
        end else if (decided) begin
            resp_q[bit_idx] <= upper_wins;
            if (!last_bit) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        resp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RACE: busy = 1'b1;
            ST_DONE: begin
                busy       = 1'b1;
                resp_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign response = resp_q;

    // R2: an accepted start raises busy on the next edge
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R7: valid is a single pulse and the block is idle right after it
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && !busy));

    // R7: the word holds while idle and not restarted
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(response));

    // R8: start in the middle of a run does not end it
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !resp_valid && start) |=> busy);

endmodule

// File: tb/race_id_gen_tb.sv
module race_id_gen_tb;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned CHAL_W = 16;
    localparam int unsigned RESP_W = 8;
    localparam logic [31:0] SEED_A = 32'h1F2E3D4C;
    localparam logic [31:0] SEED_B = 32'h00C0FFEE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [15:0]       chal_seed = '0;
    logic              busy_a, valid_a, busy_b, valid_b;
    logic [RESP_W-1:0] resp_a, resp_b;

    int checks = 0;
    int failures = 0;
    int diff_count = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    race_id_gen #(.CHAL_W(CHAL_W), .RESP_W(RESP_W), .SEED(SEED_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .chal_seed(chal_seed),
        .busy(busy_a), .resp_valid(valid_a), .response(resp_a));

    race_id_gen #(.CHAL_W(CHAL_W), .RESP_W(RESP_W), .SEED(SEED_B)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .start(start), .chal_seed(chal_seed),
        .busy(busy_b), .resp_valid(valid_b), .response(resp_b));

    function automatic int dly(input logic [31:0] s, input int i, input int st, input int ln);
        logic [31:0] h;
        logic [31:0] idx;
        idx = 32'(4 * i + 2 * st + ln);
        h = s ^ (idx * 32'h9E3779B9);
        h = h ^ (h >> 16);
        h = h * 32'h045D9F3B;
        h = h ^ (h >> 16);
        return int'(h[1:0]) + 1;
    endfunction

    function automatic logic [15:0] lfsr_step(input logic [15:0] v);
        logic [15:0] n;
        n = v >> 1;
        if (v[0]) n = n ^ 16'hB400;
        return n;
    endfunction

    // model of R3..R6 and R11
    task automatic model(input logic [31:0] s, input logic [15:0] cs,
                         output logic [RESP_W-1:0] r, output int lat);
        logic [15:0] l;
        int up, lo, nu, nl, first;
        l = (cs == 16'h0) ? 16'h1 : cs;
        r = '0;
        lat = 0;
        for (int k = 0; k < RESP_W; k++) begin
            up = 0;
            lo = 0;
            for (int i = 0; i < CHAL_W; i++) begin
                if (l[i]) begin
                    nu = lo + dly(s, i, 1, 1);
                    nl = up + dly(s, i, 1, 0);
                end else begin
                    nu = up + dly(s, i, 0, 0);
                    nl = lo + dly(s, i, 0, 1);
                end
                up = nu;
                lo = nl;
            end
            r[k] = (up < lo);
            first = (up < lo) ? up : lo;
            lat = lat + first + 1;
            l = lfsr_step(l);
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // runs one response; optional stray start with another seed mid-run
    task automatic run(input logic [15:0] cs, input bit stray,
                       output logic [RESP_W-1:0] ra, output logic [RESP_W-1:0] rb,
                       output int lat, output bit busy_ok);
        bit got_a, got_b;
        int n;
        got_a = 0;
        got_b = 0;
        n = 0;
        lat = -1;
        ra = '0;
        rb = '0;
        @(negedge clk);
        chal_seed = cs;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        busy_ok = busy_a;
        while (!(got_a && got_b) && n < 5000) begin
            if (stray && n == 3) begin
                chal_seed = cs ^ 16'h5A5A;
                start = 1'b1;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
            start = 1'b0;
            if (valid_a && !got_a) begin
                got_a = 1;
                lat = n;
            end
            if (valid_b) got_b = 1;
        end
        @(negedge clk);
        ra = resp_a;
        rb = resp_b;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        logic [RESP_W-1:0] ra, rb, ea, eb, ra2, rb2, e1;
        int lat, elat, elat_b, lat2;
        bit bok;
        logic [15:0] cs;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(busy_a == 1'b0, "R1 busy", busy_a, 0);
        check(valid_a == 1'b0, "R1 valid", valid_a, 0);
        check(resp_a == '0, "R1 response", resp_a, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: a basic seed
        run(16'hACE1, 0, ra, rb, lat, bok);
        model(SEED_A, 16'hACE1, ea, elat);
        model(SEED_B, 16'hACE1, eb, elat_b);
        check(bok, "R2 busy after start", bok, 1);
        check(ra == ea, "R3/R4/R5/R6/R7 response A", ra, ea);
        check(rb == eb, "R4/R5 response B", rb, eb);
        check(lat == elat, "R11 latency", lat, elat);
        check(!busy_a && !valid_a, "R7 idle after valid", {busy_a, valid_a}, 0);
        // R7: word held while idle
        repeat (5) @(negedge clk);
        check(resp_a == ea, "R7 hold", resp_a, ea);

        // R9: repeat same seed
        run(16'hACE1, 0, ra2, rb2, lat2, bok);
        check(ra2 == ra, "R9 reproducible", ra2, ra);
        check(lat2 == lat, "R9 same latency", lat2, lat);

        // R2: zero seed replaced by one
        run(16'h0000, 0, ra, rb, lat, bok);
        model(SEED_A, 16'h0001, e1, elat);
        check(ra == e1, "R2 zero seed", ra, e1);
        check(lat == elat, "R2/R11 zero seed latency", lat, elat);

        // R8: stray start mid-run ignored
        run(16'h1357, 1, ra, rb, lat, bok);
        model(SEED_A, 16'h1357, ea, elat);
        check(ra == ea, "R8 response unchanged", ra, ea);
        check(lat == elat, "R8 latency unchanged", lat, elat);

        // corner: all-ones seed
        run(16'hFFFF, 0, ra, rb, lat, bok);
        model(SEED_A, 16'hFFFF, ea, elat);
        check(ra == ea, "R5/R6 all-ones seed", ra, ea);

        // random seeds, both instances
        for (int t = 0; t < 40; t++) begin
            cs = 16'($urandom);
            run(cs, 0, ra, rb, lat, bok);
            model(SEED_A, cs, ea, elat);
            model(SEED_B, cs, eb, elat_b);
            check(ra == ea, "R3/R4/R5/R6 random A", ra, ea);
            check(rb == eb, "R4/R5/R6 random B", rb, eb);
            check(lat == elat, "R11 random latency", lat, elat);
            if (ra != rb) diff_count++;
        end
        // R10: the two seeded instances disagree somewhere
        check(diff_count > 0, "R10 instances differ", diff_count, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule